// File: doc/BRIEF.md
# Flash Controller Command and Status Front End

This block is the register front end of an embedded flash memory controller. A host reaches it through a simple memory-mapped bus with separate read and write strobes and a three-bit word offset. Software sets up a mode, a target address and a data word, then writes a command code. A timed operation starts on a small internal word array that stands in for the flash cells. A read-only status register reports whether the controller is busy and whether the last command succeeded or failed. It also holds an interrupt flag, which drives a level interrupt output.

Erasing the whole array is guarded. The erase runs only when three conditions hold: the key-enable mode bit is set, the address and data registers hold two fixed key values, and the external protection word is all ones. If any of these is missing, the command fails at once. Unknown command codes fail the same way. The success, fail and interrupt flags are sticky and clear when the status register is read.

Register offsets on the bus are: 0 status (read-only), 1 mode, 2 address, 3 data, 4 command (write-only, reads as zero).

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the status, mode, address and data registers all read 0x0000, and `irq_o` is low.
- R2: Status bit positions are as follows: bit 0 is success, bit 1 is fail, bit 2 is busy and bit 3 is interrupt. Bits 15 to 4 always read 0.
- R3: A status read returns the flags as they were before the read. The same clock edge then clears success, fail and interrupt. A completion on that same edge still sets its flags.
- R4: An accepted command keeps busy at 1 for exactly BUSY_CYCLES cycles, starting on the edge that takes the command write. Status reads do not change busy. Success is set on the edge where busy falls.
- R5: A write to the command register while busy is 1 is ignored. It changes neither the flags nor the running operation.
- R6: The command code sits in data bits 7:0 of the command write. Code 0x02 stores the data register into the array word that the low address bits select. Code 0x01 loads that word into the data register when the command completes.
- R7: The interrupt flag is set on the completion of a timed command only if mode bit 4 is 1. Immediate failures never set it. `irq_o` follows the status interrupt bit.
- R8: Code 0x06 runs a mass erase only if four conditions hold: mode bit 3 is 1, the address register is 0xFFC3, the data register is 0x3CFF and `prot_word` is 0xFFFFFFFF. On completion every array word becomes 0xFFFF.
- R9: A mass erase that lacks any of the R8 conditions sets fail on the next cycle. It does not go busy and leaves the array unchanged.
- R10: Any code other than 0x01, 0x02 and 0x06 sets fail on the next cycle without going busy.
- R11: Mode keeps only bits 3 and 4, and the other mode bits read 0. The address and data registers read back the full 16 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the offset |
| prot_word | input | 32 | Protection word; all ones means protection is lifted |
| irq_o | output | 1 | Level interrupt, equal to status bit 3 |

## Verification
The bench reads status on every busy cycle to pin down the exact length of busy. A design whose count was off by one would show success one cycle early or late. The bench also lets a status read land on the completion edge; a design that gave the clear priority over the set would lose the success flag. It tries each erase key condition on its own, including a protection word that is one bit short of all ones, and then reads back an array word. A design that checked only part of the key would wipe the array. A command written while busy must not raise fail or restart the timer, so a design that dropped the busy guard would end up with a wrong status pattern.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int REG_W = 16;
    localparam int OFF_W = 3;

    localparam logic [OFF_W-1:0] OFF_STAT = 3'd0;
    localparam logic [OFF_W-1:0] OFF_MODE = 3'd1;
    localparam logic [OFF_W-1:0] OFF_ADDR = 3'd2;
    localparam logic [OFF_W-1:0] OFF_DATA = 3'd3;
    localparam logic [OFF_W-1:0] OFF_CMD  = 3'd4;

    typedef enum logic [7:0] {
        OP_READ  = 8'h01,
        OP_WRITE = 8'h02,
        OP_ERASE = 8'h06
    } op_e;

    localparam logic [REG_W-1:0] ERASE_KEY_ADDR = 16'hFFC3;
    localparam logic [REG_W-1:0] ERASE_KEY_DATA = 16'h3CFF;
    localparam logic [31:0]      PROT_OPEN      = 32'hFFFF_FFFF;

    localparam int BIT_SUCC = 0;
    localparam int BIT_FAIL = 1;
    localparam int BIT_BUSY = 2;
    localparam int BIT_IRQ  = 3;
    localparam int MODE_KEY = 3;
    localparam int MODE_IE  = 4;
endpackage

// File: rtl/fc_cmd_check.sv
module fc_cmd_check
    import flash_cmd_pkg::*;
(
    input  logic [7:0]       code,
    input  logic             key_en,
    input  logic [REG_W-1:0] addr,
    input  logic [REG_W-1:0] data,
    input  logic [31:0]      prot,
    output logic             accept
);
    logic erase_ok;

    always_comb begin
        erase_ok = key_en && (addr == ERASE_KEY_ADDR) &&
                   (data == ERASE_KEY_DATA) && (prot == PROT_OPEN);
        case (code)
            OP_READ, OP_WRITE: accept = 1'b1;
            OP_ERASE:          accept = erase_ok;
            default:           accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/fc_busy_timer.sv
module fc_busy_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start && cnt_q == '0) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);
endmodule

// File: rtl/fc_word_store.sv
module fc_word_store
    import flash_cmd_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             erase_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (erase_en) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[idx];

    p_erase_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem_q[0] == '1 && mem_q[WORDS-1] == '1));
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import flash_cmd_pkg::*;
#(
    parameter int WORDS       = 16,
    parameter int BUSY_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [OFF_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [31:0]      prot_word,
    output logic             irq_o
);
    localparam int IDX_W = $clog2(WORDS);

    typedef struct packed {
        logic             ie;
        logic             key;
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
        logic             succ;
        logic             fail;
        logic             irq;
        logic [7:0]       op;
        logic [IDX_W-1:0] op_idx;
        logic [REG_W-1:0] op_data;
    } state_t;

    state_t st_d, st_q;

    logic             busy, done, accept;
    logic             wr_hit_mode, wr_hit_addr, wr_hit_data, cmd_wr, rd_stat;
    logic             go, rej;
    logic [REG_W-1:0] store_rd;
    logic [IDX_W-1:0] store_idx;

    fc_cmd_check u_check (
        .code   (bus_wdata[7:0]),
        .key_en (st_q.key),
        .addr   (st_q.addr),
        .data   (st_q.data),
        .prot   (prot_word),
        .accept (accept)
    );

    fc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .busy  (busy),
        .done  (done)
    );

    assign store_idx = busy ? st_q.op_idx : st_q.addr[IDX_W-1:0];

    fc_word_store #(.WORDS(WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (done && st_q.op == OP_WRITE),
        .erase_en (done && st_q.op == OP_ERASE),
        .idx      (store_idx),
        .wr_data  (st_q.op_data),
        .rd_data  (store_rd)
    );

    always_comb begin
        wr_hit_mode = bus_sel && bus_wr && (bus_addr == OFF_MODE);
        wr_hit_addr = bus_sel && bus_wr && (bus_addr == OFF_ADDR);
        wr_hit_data = bus_sel && bus_wr && (bus_addr == OFF_DATA);
        cmd_wr      = bus_sel && bus_wr && (bus_addr == OFF_CMD) && !busy;
        rd_stat     = bus_sel && bus_rd && (bus_addr == OFF_STAT);
        go          = cmd_wr && accept;
        rej         = cmd_wr && !accept;

        st_d = st_q;
        if (wr_hit_mode) begin
            st_d.ie  = bus_wdata[MODE_IE];
            st_d.key = bus_wdata[MODE_KEY];
        end
        if (wr_hit_addr) st_d.addr = bus_wdata;
        if (wr_hit_data) st_d.data = bus_wdata;
        if (rd_stat) begin
            st_d.succ = 1'b0;
            st_d.fail = 1'b0;
            st_d.irq  = 1'b0;
        end
        if (go) begin
            st_d.op      = bus_wdata[7:0];
            st_d.op_idx  = st_q.addr[IDX_W-1:0];
            st_d.op_data = st_q.data;
        end
        if (rej) st_d.fail = 1'b1;
        if (done) begin
            st_d.succ = 1'b1;
            if (st_q.ie) st_d.irq = 1'b1;
            if (st_q.op == OP_READ) st_d.data = store_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_STAT: begin
                bus_rdata[BIT_SUCC] = st_q.succ;
                bus_rdata[BIT_FAIL] = st_q.fail;
                bus_rdata[BIT_BUSY] = busy;
                bus_rdata[BIT_IRQ]  = st_q.irq;
            end
            OFF_MODE: begin
                bus_rdata[MODE_IE]  = st_q.ie;
                bus_rdata[MODE_KEY] = st_q.key;
            end
            OFF_ADDR: bus_rdata = st_q.addr;
            OFF_DATA: bus_rdata = st_q.data;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !done && !rej) |=> (!st_q.succ && !st_q.fail && !st_q.irq));
    p_busy_not_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && rd_stat) |=> busy);
    p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !rd_stat) |=> $stable(st_q.fail) && $stable(st_q.op));
    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(st_q.ie) && $past(done));
    p_reject_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rej && !busy) |=> (!busy && st_q.fail));
endmodule

// File: tb/flash_cmd_front_tb.sv
module flash_cmd_front_tb;
    localparam int WORDS = 8;
    localparam int BUSY  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] prot_word = 32'hFFFF_FFFF;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        rd_ev;

    always #2 clk = ~clk;

    flash_cmd_front #(.WORDS(WORDS), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .prot_word(prot_word), .irq_o(irq_o)
    );

    // monitor: pops expected values as reads are presented
    always begin
        @(rd_ev);
        checks++;
        if (bus_rdata !== exp_q[0]) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag_q[0], bus_rdata, exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
    end

    task automatic wr(input logic [2:0] off, input logic [15:0] val);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = val;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, input logic [15:0] exp, input string tag);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = off;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #1 -> rd_ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic busy_reads(input string tag);
        for (int i = 0; i < BUSY; i++) rd(3'd0, 16'h0004, tag);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s: irq_o got %b expected %b", tag, irq_o, exp);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(3'd0, 16'h0000, "R1 status");
        rd(3'd1, 16'h0000, "R1 mode");
        rd(3'd2, 16'h0000, "R1 addr");
        rd(3'd3, 16'h0000, "R1 data");
        chk_irq(1'b0, "R1 irq");

        // R11 register read back
        wr(3'd1, 16'hFFFF);
        rd(3'd1, 16'h0018, "R11 mode reserved");
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h1234);
        rd(3'd2, 16'h1234, "R11 addr");
        wr(3'd3, 16'hABCD);
        rd(3'd3, 16'hABCD, "R11 data");
        rd(3'd4, 16'h0000, "R11 command reads zero");

        // R6 write word 3, R4 busy length, R5 ignore, R3 read on completion
        wr(3'd2, 16'h0003);
        wr(3'd3, 16'h5A5A);
        wr(3'd4, 16'h0002);
        rd(3'd0, 16'h0004, "R4 busy c0");
        wr(3'd4, 16'h007F);
        rd(3'd0, 16'h0004, "R5 busy after ignored write");
        rd(3'd0, 16'h0004, "R4 busy c3");
        rd(3'd0, 16'h0004, "R4 busy c4");
        rd(3'd0, 16'h0001, "R3 R4 R2 success kept on completion edge");
        rd(3'd0, 16'h0000, "R3 cleared by read");

        // R6 read back word 3
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0002);
        busy_reads("R4 write zero busy");
        rd(3'd0, 16'h0001, "R6 write done");
        wr(3'd3, 16'h1111);
        wr(3'd2, 16'h0005);
        wr(3'd4, 16'h0002);
        busy_reads("R6 second write busy");
        rd(3'd0, 16'h0001, "R6 second write done");
        wr(3'd2, 16'h0003);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0001);
        busy_reads("R6 read busy");
        rd(3'd0, 16'h0001, "R6 read done");
        rd(3'd3, 16'h0000, "R6 word 3 holds last write");
        wr(3'd2, 16'h0005);
        wr(3'd4, 16'h0001);
        busy_reads("R6 read5 busy");
        rd(3'd0, 16'h0001, "R7 no irq with enable clear");
        rd(3'd3, 16'h1111, "R6 word 5 read back");

        // R7 interrupt enabled
        wr(3'd1, 16'h0010);
        wr(3'd3, 16'h5A5A);
        wr(3'd2, 16'h0003);
        wr(3'd4, 16'h0002);
        busy_reads("R7 busy");
        chk_irq(1'b1, "R7 irq raised");
        rd(3'd0, 16'h0009, "R7 R2 status with irq");
        chk_irq(1'b0, "R7 irq cleared by read");

        // R9 erase conditions missing (irq enable on: no irq expected)
        wr(3'd2, 16'hFFC3);
        wr(3'd3, 16'h3CFF);
        wr(3'd4, 16'h0006);
        rd(3'd0, 16'h0002, "R9 key bit clear fails idle");
        chk_irq(1'b0, "R7 R9 no irq on immediate fail");
        wr(3'd1, 16'h0018);
        wr(3'd2, 16'hFFC2);
        wr(3'd4, 16'h0006);
        rd(3'd0, 16'h0002, "R9 wrong address");
        wr(3'd2, 16'hFFC3);
        wr(3'd3, 16'h3CFE);
        wr(3'd4, 16'h0006);
        rd(3'd0, 16'h0002, "R9 wrong data");
        wr(3'd3, 16'h3CFF);
        prot_word = 32'hFFFF_FFFE;
        wr(3'd4, 16'h0006);
        rd(3'd0, 16'h0002, "R9 protected");
        prot_word = 32'hFFFF_FFFF;

        // R10 unknown code
        wr(3'd4, 16'h0033);
        rd(3'd0, 16'h0002, "R10 unknown code fails idle");
        rd(3'd0, 16'h0000, "R10 fail cleared");

        // R9 array unchanged
        wr(3'd2, 16'h0003);
        wr(3'd4, 16'h0001);
        busy_reads("R9 check busy");
        rd(3'd0, 16'h0009, "R9 check done");
        rd(3'd3, 16'h5A5A, "R9 array unchanged");

        // R8 successful mass erase
        wr(3'd2, 16'hFFC3);
        wr(3'd3, 16'h3CFF);
        wr(3'd4, 16'h0006);
        busy_reads("R8 erase busy");
        rd(3'd0, 16'h0009, "R8 erase success");
        wr(3'd2, 16'h0005);
        wr(3'd4, 16'h0001);
        busy_reads("R8 read busy");
        rd(3'd0, 16'h0009, "R8 read done");
        rd(3'd3, 16'hFFFF, "R8 word 5 erased");
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'h0001);
        busy_reads("R8 read0 busy");
        rd(3'd0, 16'h0009, "R8 read0 done");
        rd(3'd3, 16'hFFFF, "R8 word 0 erased");

        repeat (2) @(negedge clk);
        summary();
    end
endmodule